// File: doc/BRIEF.md
# Device-to-Host Frame Shadow Status Tracker

This block is the receive side of a host adapter. It looks at each frame the device sends back and keeps the host's copies of the device status and error bytes up to date. Frames arrive as a stream of 32-bit dwords. A valid strobe qualifies each dword, and start and end markers bound each frame. The block reads the type code from the low byte of the first dword and counts the dwords of the frame. It then checks the count against the length that type must have. A frame that passes is applied, all at once, after its last dword. A frame that fails is discarded and reported on a one-cycle protocol-error pulse.

Each frame type has its own update rule. A register response overwrites both shadow bytes. A programmed-I/O setup frame has two status values. Its starting value is loaded at once. Its ending value is held back until the next data frame completes, and is loaded then. A set-device-bits frame rewrites the error byte and every status bit except busy and data-request. The DMA activate, first-party DMA setup and self-test frames are checked for length and otherwise leave the shadow alone. The host reads the shadow through `status_o` and `error_o`. An interrupt flag is raised by frames that carry an interrupt bit, and the flag stays up until the host strobes `rd_status`.

Top module: `d2h_shadow_status`

## Requirements
- R1: After reset, `status_o` is 80h, `error_o` is 00h, and `irq_o`, `pio_dir_o` and `proto_err_o` are 0.
- R2: A frame is accepted only if its total dword count matches its type code in the low byte of dword 0. The legal counts are 34h→5, 39h→1, 41h→7, 58h→3, 5Fh→5 and A1h→2. Any other count, or an unknown code, drops the frame without touching the shadow. `proto_err_o` is then high for one cycle, two clock edges after the edge that takes the frame's last dword. Accepted frames update the shadow at that same second edge.
- R3: An accepted register response (34h) loads status from bits 23:16 of dword 0 and error from bits 31:24. If bit 14 is set, it raises `irq_o`. It also discards any pending ending status.
- R4: An accepted PIO setup frame (5Fh) loads status and error from the same fields as R3 and latches bit 13 (1 = device to host) onto `pio_dir_o`. If bit 14 is set, it raises `irq_o`. It holds bits 31:24 of dword 3 as a pending ending status.
- R5: When an accepted data frame (46h) completes, any pending ending status is loaded into `status_o` and the pending status is cleared. With nothing pending, the data frame changes nothing.
- R6: An accepted set-device-bits frame (A1h) loads error from bits 31:24 of dword 0. It copies bits 22:20 into status bits 6:4 and bits 18:16 into status bits 2:0. Status bits 7 (busy) and 3 (data-request) keep their values. If bit 14 is set, it raises `irq_o`.
- R7: `irq_o` stays high until a cycle with `rd_status` high clears it. When a new interrupt and a read fall on the same update, the new interrupt wins and `irq_o` stays high.
- R8: Accepted 39h, 41h and 58h frames leave status, error and the interrupt flag unchanged and raise no protocol error.
- R9: A start marker that arrives while a frame is still open abandons the open frame and gives one `proto_err_o` pulse. The new frame is then processed normally.
- R10: Cycles with `rd_valid` low between the dwords of a frame are ignored. The frame is handled as if its dwords were back to back.
- R11: A data frame is legal from 2 to MAX_DATA_DW+1 dwords (2049 by default). At 1 dword or at 2050 it is rejected as in R2, and any pending ending status stays pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_valid | input | 1 | Dword qualifier for the receive stream |
| rd_sof | input | 1 | Marks the first dword of a frame |
| rd_eof | input | 1 | Marks the last dword of a frame |
| rd_data | input | DW | Received dword |
| rd_status | input | 1 | Host status read strobe; clears the interrupt flag |
| status_o | output | 8 | Shadow status byte |
| error_o | output | 8 | Shadow error byte |
| irq_o | output | 1 | Interrupt pending flag |
| pio_dir_o | output | 1 | Direction of the last accepted PIO setup frame |
| proto_err_o | output | 1 | One-cycle pulse for a dropped or abandoned frame |

## Verification
Four properties are checked every cycle. A set-device-bits update preserves busy and data-request. The interrupt flag holds until it is read. A rejected frame leaves both shadow bytes stable. A data frame with nothing pending leaves status unchanged. The register-response load is checked against the captured header byte. Other behaviour needs frame sequences that only the bench's scenarios build: the deferral of ending status across a later data frame, its cancellation by a register response, the length limits of data frames, abandoned frames and stalled streams.

// File: rtl/d2h_pkg.sv
package d2h_pkg;

   // frame type codes, low byte of dword 0
   localparam logic [7:0] TY_REG  = 8'h34;
   localparam logic [7:0] TY_ACT  = 8'h39;
   localparam logic [7:0] TY_FDMA = 8'h41;
   localparam logic [7:0] TY_DATA = 8'h46;
   localparam logic [7:0] TY_BIST = 8'h58;
   localparam logic [7:0] TY_PIO  = 8'h5F;
   localparam logic [7:0] TY_SDB  = 8'hA1;

   // status bits left alone by a set-device-bits frame
   localparam int ST_BUSY = 7;
   localparam int ST_XREQ = 3;

   // header field positions in dword 0
   localparam int HB_IRQ = 14;
   localparam int HB_DIR = 13;

   localparam logic [7:0] STATUS_RST = 8'h80;

   typedef enum logic [2:0] {
      K_NONE,
      K_REG,
      K_PIO,
      K_DATA,
      K_SDB,
      K_QUIET,
      K_BAD
   } kind_e;

   // fixed dword count for a type; 0 = variable or unknown
   function automatic int fixed_len(input logic [7:0] ty);
      case (ty)
         TY_REG:  return 5;
         TY_ACT:  return 1;
         TY_FDMA: return 7;
         TY_BIST: return 3;
         TY_PIO:  return 5;
         TY_SDB:  return 2;
         default: return 0;
      endcase
   endfunction

endpackage

// File: rtl/d2h_frame_tracker.sv
module d2h_frame_tracker #(
   parameter int DW = 32,
   parameter int CW = 13
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_valid,
   input  logic          rd_sof,
   input  logic          rd_eof,
   input  logic [DW-1:0] rd_data,
   output logic          done_o,
   output logic          abort_o,
   output logic [CW-1:0] len_o,
   output logic [DW-1:0] head_o,
   output logic [DW-1:0] fourth_o
);

   localparam logic [CW-1:0] CNT_MAX   = '1;
   localparam logic [CW-1:0] IDX_FOUR  = CW'(3);
   localparam logic [CW-1:0] CNT_FIRST = CW'(1);

   logic          open_q;
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] cnt_inc;

   // saturating count so long frames cannot wrap into a legal length
   always_comb begin
      if (cnt_q == CNT_MAX) cnt_inc = cnt_q;
      else                  cnt_inc = cnt_q + CW'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_q   <= 1'b0;
         cnt_q    <= '0;
         done_o   <= 1'b0;
         abort_o  <= 1'b0;
         len_o    <= '0;
         head_o   <= '0;
         fourth_o <= '0;
      end else begin
         done_o  <= 1'b0;
         abort_o <= 1'b0;
         if (rd_valid) begin
            if (rd_sof) begin
               abort_o <= open_q;
               head_o  <= rd_data;
               cnt_q   <= CNT_FIRST;
               if (rd_eof) begin
                  done_o <= 1'b1;
                  len_o  <= CNT_FIRST;
                  open_q <= 1'b0;
               end else begin
                  open_q <= 1'b1;
               end
            end else if (open_q) begin
               cnt_q <= cnt_inc;
               if (cnt_q == IDX_FOUR) fourth_o <= rd_data;
               if (rd_eof) begin
                  done_o <= 1'b1;
                  len_o  <= cnt_inc;
                  open_q <= 1'b0;
               end
            end
         end
      end
   end

endmodule

// File: rtl/d2h_frame_classifier.sv
module d2h_frame_classifier
   import d2h_pkg::*;
#(
   parameter int DW          = 32,
   parameter int CW          = 13,
   parameter int MAX_DATA_DW = 2048
) (
   input  logic          done_i,
   input  logic [CW-1:0] len_i,
   input  logic [DW-1:0] head_i,
   output kind_e         kind_o
);

   localparam logic [CW-1:0] DATA_MIN = CW'(2);
   localparam logic [CW-1:0] DATA_MAX = CW'(MAX_DATA_DW + 1);

   logic [7:0] ty;
   logic       len_fixed_ok;
   logic       len_data_ok;

   assign ty           = head_i[7:0];
   assign len_fixed_ok = (fixed_len(ty) != 0) && (len_i == CW'(fixed_len(ty)));
   assign len_data_ok  = (len_i >= DATA_MIN) && (len_i <= DATA_MAX);

   always_comb begin
      kind_o = K_NONE;
      if (done_i) begin
         case (ty)
            TY_REG:  kind_o = len_fixed_ok ? K_REG  : K_BAD;
            TY_PIO:  kind_o = len_fixed_ok ? K_PIO  : K_BAD;
            TY_SDB:  kind_o = len_fixed_ok ? K_SDB  : K_BAD;
            TY_DATA: kind_o = len_data_ok  ? K_DATA : K_BAD;
            TY_ACT, TY_FDMA, TY_BIST:
                     kind_o = len_fixed_ok ? K_QUIET : K_BAD;
            default: kind_o = K_BAD;
         endcase
      end
   end

endmodule

// File: rtl/d2h_shadow_bank.sv
module d2h_shadow_bank
   import d2h_pkg::*;
#(
   parameter bit SET_OVER_CLEAR = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  kind_e      kind_i,
   input  logic       abort_i,
   input  logic [7:0] hdr_status_i,
   input  logic [7:0] hdr_error_i,
   input  logic       hdr_irq_i,
   input  logic       hdr_dir_i,
   input  logic [7:0] end_status_i,
   input  logic       rd_status,
   output logic [7:0] status_o,
   output logic [7:0] error_o,
   output logic       irq_o,
   output logic       pio_dir_o,
   output logic       proto_err_o,
   output logic       pend_o,
   output logic       set_evt_o
);

   logic [7:0] end_q;
   logic [7:0] sdb_status;

   // merge set-device-bits fields, keeping busy and data-request
   always_comb begin
      sdb_status          = {1'b0, hdr_status_i[6:4], 1'b0, hdr_status_i[2:0]};
      sdb_status[ST_BUSY] = status_o[ST_BUSY];
      sdb_status[ST_XREQ] = status_o[ST_XREQ];
   end

   assign set_evt_o = hdr_irq_i &&
                      (kind_i == K_REG || kind_i == K_PIO || kind_i == K_SDB);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_o    <= STATUS_RST;
         error_o     <= 8'h00;
         pio_dir_o   <= 1'b0;
         pend_o      <= 1'b0;
         end_q       <= 8'h00;
         proto_err_o <= 1'b0;
      end else begin
         proto_err_o <= abort_i || (kind_i == K_BAD);
         case (kind_i)
            K_REG: begin
               status_o <= hdr_status_i;
               error_o  <= hdr_error_i;
               pend_o   <= 1'b0;
            end
            K_PIO: begin
               status_o  <= hdr_status_i;
               error_o   <= hdr_error_i;
               pio_dir_o <= hdr_dir_i;
               end_q     <= end_status_i;
               pend_o    <= 1'b1;
            end
            K_DATA: begin
               if (pend_o) begin
                  status_o <= end_q;
                  pend_o   <= 1'b0;
               end
            end
            K_SDB: begin
               status_o <= sdb_status;
               error_o  <= hdr_error_i;
            end
            default: ;
         endcase
      end
   end

   generate
      if (SET_OVER_CLEAR) begin : g_set_wins
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         irq_o <= 1'b0;
            else if (set_evt_o) irq_o <= 1'b1;
            else if (rd_status) irq_o <= 1'b0;
         end
      end else begin : g_clear_wins
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         irq_o <= 1'b0;
            else if (rd_status) irq_o <= 1'b0;
            else if (set_evt_o) irq_o <= 1'b1;
         end
      end
   endgenerate

endmodule

// File: rtl/d2h_shadow_status.sv
module d2h_shadow_status
   import d2h_pkg::*;
#(
   parameter int DW             = 32,
   parameter int MAX_DATA_DW    = 2048,
   parameter bit SET_OVER_CLEAR = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_valid,
   input  logic          rd_sof,
   input  logic          rd_eof,
   input  logic [DW-1:0] rd_data,
   input  logic          rd_status,
   output logic [7:0]    status_o,
   output logic [7:0]    error_o,
   output logic          irq_o,
   output logic          pio_dir_o,
   output logic          proto_err_o
);

   localparam int CW = $clog2(MAX_DATA_DW + 2) + 1;

   generate
      if (DW != 32) begin : g_bad_dw
         $error("d2h_shadow_status: DW must be 32");
      end
      if (MAX_DATA_DW < 1 || MAX_DATA_DW > 65536) begin : g_bad_max
         $error("d2h_shadow_status: MAX_DATA_DW out of range");
      end
   endgenerate

   logic          done;
   logic          abort;
   logic [CW-1:0] len;
   logic [DW-1:0] head;
   logic [DW-1:0] fourth;
   kind_e         kind;
   logic          pend;
   logic          set_evt;
   logic          unused_bits;

   assign unused_bits = ^{head[15], head[12:8], fourth[23:0]};

   d2h_frame_tracker #(
      .DW (DW),
      .CW (CW)
   ) u_trk (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_valid (rd_valid),
      .rd_sof   (rd_sof),
      .rd_eof   (rd_eof),
      .rd_data  (rd_data),
      .done_o   (done),
      .abort_o  (abort),
      .len_o    (len),
      .head_o   (head),
      .fourth_o (fourth)
   );

   d2h_frame_classifier #(
      .DW          (DW),
      .CW          (CW),
      .MAX_DATA_DW (MAX_DATA_DW)
   ) u_cls (
      .done_i (done),
      .len_i  (len),
      .head_i (head),
      .kind_o (kind)
   );

   d2h_shadow_bank #(
      .SET_OVER_CLEAR (SET_OVER_CLEAR)
   ) u_bank (
      .clk          (clk),
      .rst_n        (rst_n),
      .kind_i       (kind),
      .abort_i      (abort),
      .hdr_status_i (head[23:16]),
      .hdr_error_i  (head[31:24]),
      .hdr_irq_i    (head[HB_IRQ]),
      .hdr_dir_i    (head[HB_DIR]),
      .end_status_i (fourth[31:24]),
      .rd_status    (rd_status),
      .status_o     (status_o),
      .error_o      (error_o),
      .irq_o        (irq_o),
      .pio_dir_o    (pio_dir_o),
      .proto_err_o  (proto_err_o),
      .pend_o       (pend),
      .set_evt_o    (set_evt)
   );

endmodule

// File: rtl/d2h_shadow_status_chk.sv
module d2h_shadow_status_chk
   import d2h_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input kind_e      kind,
   input logic       pend,
   input logic       set_evt,
   input logic [7:0] hdr_status,
   input logic       rd_status,
   input logic [7:0] status_o,
   input logic [7:0] error_o,
   input logic       irq_o
);

   // R6: busy and data-request survive a set-device-bits update
   a_r6_keep_busy_xreq: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == K_SDB) |=> (status_o[ST_BUSY] == $past(status_o[ST_BUSY]))
                       && (status_o[ST_XREQ] == $past(status_o[ST_XREQ])));

   // R7: the flag holds until a read
   a_r7_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !rd_status) |=> irq_o);

   // R7: a read with no new event clears the flag
   a_r7_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_status && !set_evt) |=> !irq_o);

   // R2: a rejected frame leaves the shadow bytes alone
   a_r2_bad_no_change: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == K_BAD) |=> ($stable(status_o) && $stable(error_o)));

   // R5: a data frame with nothing pending changes nothing
   a_r5_data_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == K_DATA && !pend) |=> $stable(status_o));

   // R3: register response loads the header status byte
   a_r3_reg_load: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == K_REG) |=> (status_o == $past(hdr_status)));

endmodule

bind d2h_shadow_status d2h_shadow_status_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .kind       (kind),
   .pend       (pend),
   .set_evt    (set_evt),
   .hdr_status (head[23:16]),
   .rd_status  (rd_status),
   .status_o   (status_o),
   .error_o    (error_o),
   .irq_o      (irq_o)
);

// File: tb/d2h_shadow_status_tb_top.sv
`timescale 1ns/1ps
module d2h_shadow_status_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rd_valid = 1'b0;
   logic        rd_sof = 1'b0;
   logic        rd_eof = 1'b0;
   logic [31:0] rd_data = '0;
   logic        rd_status = 1'b0;
   logic [7:0]  status_o;
   logic [7:0]  error_o;
   logic        irq_o;
   logic        pio_dir_o;
   logic        proto_err_o;

   int n_run = 0;
   int n_fail = 0;
   int perr_seen = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   d2h_shadow_status dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .rd_valid    (rd_valid),
      .rd_sof      (rd_sof),
      .rd_eof      (rd_eof),
      .rd_data     (rd_data),
      .rd_status   (rd_status),
      .status_o    (status_o),
      .error_o     (error_o),
      .irq_o       (irq_o),
      .pio_dir_o   (pio_dir_o),
      .proto_err_o (proto_err_o)
   );

   always @(negedge clk) if (proto_err_o) perr_seen++;

   typedef struct packed {
      logic [15:0] len;
      logic [31:0] w0;
      logic [31:0] w3;
      logic [7:0]  st;
      logic [7:0]  er;
      logic        irq;
      logic        pe;
      logic        dir;
      logic [3:0]  req;
   } vec_t;

   // len, dword0, dword3, status, error, irq, perr, dir, requirement
   localparam vec_t VECS [22] = '{
      '{16'd5,  32'h0050_4034, 32'h0, 8'h50, 8'h00, 1'b1, 1'b0, 1'b0, 4'd3},  // R3
      '{16'd4,  32'h0451_4034, 32'h0, 8'h50, 8'h00, 1'b0, 1'b1, 1'b0, 4'd2},  // R2 short
      '{16'd5,  32'h0058_605F, 32'hD000_0000, 8'h58, 8'h00, 1'b1, 1'b0, 1'b1, 4'd4}, // R4
      '{16'd10, 32'h0000_0046, 32'h0, 8'hD0, 8'h00, 1'b0, 1'b0, 1'b1, 4'd5},  // R5
      '{16'd5,  32'h0058_405F, 32'h5000_0000, 8'h58, 8'h00, 1'b1, 1'b0, 1'b0, 4'd4}, // R4
      '{16'd1,  32'h0000_0046, 32'h0, 8'h58, 8'h00, 1'b0, 1'b1, 1'b0, 4'd11}, // R11 min-1
      '{16'd2,  32'h0000_0046, 32'h0, 8'h50, 8'h00, 1'b0, 1'b0, 1'b0, 4'd5},  // R5 pend kept
      '{16'd3,  32'h0000_0046, 32'h0, 8'h50, 8'h00, 1'b0, 1'b0, 1'b0, 4'd5},  // R5 none
      '{16'd5,  32'h00D8_0034, 32'h0, 8'hD8, 8'h00, 1'b0, 1'b0, 1'b0, 4'd3},  // R3
      '{16'd2,  32'h0477_40A1, 32'h0, 8'hFF, 8'h04, 1'b1, 1'b0, 1'b0, 4'd6},  // R6
      '{16'd2,  32'h0000_00A1, 32'h0, 8'h88, 8'h00, 1'b0, 1'b0, 1'b0, 4'd6},  // R6
      '{16'd5,  32'h0050_0034, 32'h0, 8'h50, 8'h00, 1'b0, 1'b0, 1'b0, 4'd3},  // R3
      '{16'd2,  32'h0088_00A1, 32'h0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 4'd6},  // R6 ignores 7,3
      '{16'd1,  32'h0000_0039, 32'h0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 4'd8},  // R8
      '{16'd7,  32'h00FF_4041, 32'h0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 4'd8},  // R8
      '{16'd3,  32'h00FF_4058, 32'h0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 4'd8},  // R8
      '{16'd2,  32'h0000_0039, 32'h0, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 4'd2},  // R2
      '{16'd5,  32'h0050_4027, 32'h0, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 4'd2},  // R2 unknown
      '{16'd3,  32'h0477_40A1, 32'h0, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 4'd2},  // R2
      '{16'd5,  32'h0058_005F, 32'hD000_0000, 8'h58, 8'h00, 1'b0, 1'b0, 1'b0, 4'd4}, // R4
      '{16'd5,  32'h0151_4034, 32'h0, 8'h51, 8'h01, 1'b1, 1'b0, 1'b0, 4'd3},  // R3 cancel
      '{16'd2,  32'h0000_0046, 32'h0, 8'h51, 8'h01, 1'b0, 1'b0, 1'b0, 4'd3}   // R3 no pend
   };

   task automatic check(input string what, input int req,
                        input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // drives one frame; result is sampled after the task returns
   task automatic send(input int len, input logic [31:0] w0, input logic [31:0] w3,
                       input int gap, input bit rd_last);
      for (int i = 0; i < len; i++) begin
         if (i > 0) begin
            for (int g = 0; g < gap; g++) begin
               @(negedge clk);
               rd_valid = 1'b0;
            end
         end
         @(negedge clk);
         rd_valid = 1'b1;
         rd_sof   = (i == 0);
         rd_eof   = (i == len - 1);
         rd_data  = (i == 0) ? w0 : (i == 3) ? w3 : (32'hA5A5_0000 | i);
      end
      @(negedge clk);
      rd_valid  = 1'b0;
      rd_sof    = 1'b0;
      rd_eof    = 1'b0;
      rd_status = rd_last;
      @(negedge clk);
      rd_status = 1'b0;
   endtask

   task automatic read_status();
      @(negedge clk);
      rd_status = 1'b1;
      @(negedge clk);
      rd_status = 1'b0;
   endtask

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
   endtask

   initial begin
      #(200000 * 4);
      if (!finished) begin
         n_fail++;
         $display("FAIL R1 watchdog: actual running expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      int p0;
      repeat (3) @(negedge clk);
      // R1 reset values
      check("status at reset", 1, status_o, 8'h80);
      check("error at reset", 1, error_o, 8'h00);
      check("irq at reset", 1, irq_o, 0);
      check("dir at reset", 1, pio_dir_o, 0);
      check("perr at reset", 1, proto_err_o, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("status after release", 1, status_o, 8'h80);

      foreach (VECS[k]) begin
         send(int'(VECS[k].len), VECS[k].w0, VECS[k].w3, 0, 1'b0);
         check($sformatf("vec%0d status", k), int'(VECS[k].req), status_o, VECS[k].st);
         check($sformatf("vec%0d error", k), int'(VECS[k].req), error_o, VECS[k].er);
         check($sformatf("vec%0d irq", k), 7, irq_o, VECS[k].irq);
         check($sformatf("vec%0d perr", k), 2, proto_err_o, VECS[k].pe);
         check($sformatf("vec%0d dir", k), 4, pio_dir_o, VECS[k].dir);
         read_status();
      end

      // R10: stalls between dwords
      send(5, 32'h0050_0034, 32'h0, 2, 1'b0);
      check("R10 stalled frame status", 10, status_o, 8'h50);
      check("R10 stalled frame perr", 10, proto_err_o, 0);

      // R7: flag holds across idle cycles, cleared by read
      send(5, 32'h0050_4034, 32'h0, 0, 1'b0);
      repeat (5) @(negedge clk);
      check("R7 irq held", 7, irq_o, 1);
      read_status();
      check("R7 irq cleared", 7, irq_o, 0);

      // R7: read on the same update as a new interrupt
      send(5, 32'h0050_4034, 32'h0, 0, 1'b1);
      check("R7 set wins", 7, irq_o, 1);
      read_status();
      check("R7 cleared after", 7, irq_o, 0);

      // R9: start marker inside an open frame
      p0 = perr_seen;
      @(negedge clk);
      rd_valid = 1'b1; rd_sof = 1'b1; rd_eof = 1'b0; rd_data = 32'h0151_0034;
      send(5, 32'h0052_0034, 32'h0, 0, 1'b0);
      repeat (2) @(negedge clk);
      check("R9 one abort pulse", 9, perr_seen - p0, 1);
      check("R9 new frame applied", 9, status_o, 8'h52);

      // R11: data length limits
      send(5, 32'h0058_005F, 32'h5000_0000, 0, 1'b0);
      send(2049, 32'h0000_0046, 32'h0, 0, 1'b0);
      check("R11 max data accepted", 11, status_o, 8'h50);
      check("R11 max data no perr", 11, proto_err_o, 0);
      send(5, 32'h0058_005F, 32'hD000_0000, 0, 1'b0);
      send(2050, 32'h0000_0046, 32'h0, 0, 1'b0);
      check("R11 oversize rejected", 11, status_o, 8'h58);
      check("R11 oversize perr", 11, proto_err_o, 1);
      send(2, 32'h0000_0046, 32'h0, 0, 1'b0);
      check("R5 pending kept after drop", 5, status_o, 8'hD0);

      finished = 1'b1;
      summary();
      $finish;
   end

endmodule